// File: doc/BRIEF.md
# RS-485 UART Transmitter with Driver Enable

This block serialises bytes onto an asynchronous serial line for a half-duplex RS-485 transceiver. A host loads one byte at a time through a write strobe into a single-entry holding register. The block then frames the byte as a low start bit, eight data bits sent least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from a one-cycle baud pulse that an external divider supplies once per bit period.

Alongside the serial line, the block drives the transceiver's enable pin. The enable opens one to two bit periods before the start bit and closes one clock after the final stop bit. It stays open across frames that follow each other back to back, and its active level is selectable. A holding-register-empty flag rises as soon as the start bit has left the line, which gives the host almost a full frame to supply the next byte. The flag, gated by an enable, forms the transmit interrupt. A write to a full holding register is dropped and recorded in a sticky overrun flag.

Top module: `rs485_uart_tx`

## Requirements
- R1: After synchronous reset `txd` is 1, `drv_en` is at its inactive level, `empty` is 1, `overrun` is 0 and `irq` is 0.
- R2: A frame begins with a start bit of 0, followed by the 8 data bits with bit 0 first. Each bit lasts exactly one baud-pulse period, and every bit boundary falls on a clock edge where `baud_tick` is 1.
- R3: With `par_en`=1 one parity bit follows data bit 7. Its value is the XOR of the data bits when `par_odd`=0 and the inverse of that XOR when `par_odd`=1. With `par_en`=0 no parity bit is sent.
- R4: The stop field is high and lasts one bit period when `two_stop`=0 and two bit periods when `two_stop`=1. The line idles high.
- R5: `drv_en` becomes active no less than one and no more than two bit periods before the start bit's first clock.
- R6: If no byte is waiting, `drv_en` goes inactive exactly one clock after the last stop bit ends.
- R7: A byte accepted before the current frame ends starts its own start bit at the very edge where the previous stop field ends, and `drv_en` stays active without a gap.
- R8: With `de_active_low`=0 the active level of `drv_en` is 1. With `de_active_low`=1 it is 0, so the idle level is 1.
- R9: `empty` goes to 1 at the clock edge that ends the start bit, one bit period after the start bit begins. A write accepted while `empty`=1 clears `empty` on the next edge.
- R10: A write while `empty`=0 is ignored: the frame in flight and the byte waiting are unchanged. `overrun` becomes 1 and stays 1 until reset.
- R11: `irq` equals `empty` AND `irq_en`, registered, so with `irq_en` steady `irq` tracks `empty` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Select odd parity (0 selects even) |
| two_stop | input | 1 | Send two stop bits |
| de_active_low | input | 1 | Make the driver enable active low |
| irq_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial data line |
| drv_en | output | 1 | Transceiver driver enable |
| empty | output | 1 | Holding register free for a new byte |
| overrun | output | 1 | Sticky flag: a write hit a full holding register |
| irq | output | 1 | Transmit interrupt |

## Verification
A corrupted bit counter or shifter shows on `txd` within a single frame: it appears as a misplaced data, parity or stop bit at the mid-bit samples. A wrong sequencer state usually appears first on `drv_en`, as an enable that opens too late, drops between chained frames or closes at a cycle other than one clock after the stop field. A wrong holding-register flag shows as `empty` rising on an edge other than the end of the start bit, or as `irq` leaving `empty`. It also shows as a byte that was ignored yet was transmitted, all within the frame in which the fault arises.

// File: rtl/rs485_tx_pkg.sv
`timescale 1ns/1ps
package rs485_tx_pkg;
  localparam int unsigned TX_DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_START, S_DATA, S_PAR, S_STOP, S_TAIL
  } tx_state_e;

  // parity bit: even parity makes the total number of ones even
  function automatic logic parity_of(input logic [TX_DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // number of bit periods in one frame, start through last stop
  function automatic int unsigned frame_bits(input logic par_en, input logic two_stop);
    return 1 + TX_DATA_W + int'(par_en) + 1 + int'(two_stop);
  endfunction
endpackage

// File: rtl/txu_hold_reg.sv
`timescale 1ns/1ps
module txu_hold_reg
  import rs485_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [TX_DATA_W-1:0] wr_data,
  input  logic                 take,
  input  logic                 first_done,
  output logic [TX_DATA_W-1:0] hold_data,
  output logic                 pending,
  output logic                 empty,
  output logic                 empty_nx,
  output logic                 overrun
);
  logic accept, reject;

  assign accept   = wr_en & empty;
  assign reject   = wr_en & ~empty;
  assign empty_nx = accept ? 1'b0 : (first_done ? 1'b1 : empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      pending   <= 1'b0;
      empty     <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      if (accept) hold_data <= wr_data;
      if (accept)    pending <= 1'b1;
      else if (take) pending <= 1'b0;
      empty   <= empty_nx;
      overrun <= overrun | reject;
    end
  end

  assert_write_clears_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && empty) |=> !empty);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_reject_keeps_byte_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !empty) |=> $stable(hold_data));
endmodule

// File: rtl/txu_frame_seq.sv
`timescale 1ns/1ps
module txu_frame_seq
  import rs485_tx_pkg::*;
#(
  parameter int unsigned LEAD_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 pending,
  input  logic [TX_DATA_W-1:0] hold_data,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 two_stop,
  output logic                 take,
  output logic                 first_done,
  output logic                 de_nx,
  output logic                 line
);
  localparam int unsigned BCW = (TX_DATA_W > 1) ? $clog2(TX_DATA_W) : 1;
  localparam int unsigned LCW = (LEAD_TICKS > 1) ? $clog2(LEAD_TICKS) : 1;
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(TX_DATA_W - 1);
  localparam logic [LCW-1:0] LEAD_LAST = LCW'(LEAD_TICKS - 1);

  tx_state_e state, state_n;
  logic [TX_DATA_W-1:0] shift;
  logic [BCW-1:0] bit_cnt;
  logic [LCW-1:0] lead_cnt;
  logic           stop_cnt;
  logic           par_bit;
  logic           stop_last;

  assign stop_last = (stop_cnt == two_stop);
  assign de_nx     = (state_n != S_IDLE);

  always_comb begin
    state_n    = state;
    take       = 1'b0;
    first_done = 1'b0;
    unique case (state)
      S_IDLE:  if (pending) state_n = S_LEAD;
      S_LEAD:  if (tick && lead_cnt == LEAD_LAST) begin
                 state_n = S_START;
                 take    = 1'b1;
               end
      S_START: if (tick) begin
                 state_n    = S_DATA;
                 first_done = 1'b1;
               end
      S_DATA:  if (tick && bit_cnt == BIT_LAST) state_n = par_en ? S_PAR : S_STOP;
      S_PAR:   if (tick) state_n = S_STOP;
      S_STOP:  if (tick && stop_last) begin
                 if (pending) begin
                   state_n = S_START;
                   take    = 1'b1;
                 end else begin
                   state_n = S_TAIL;
                 end
               end
      S_TAIL:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      shift    <= '0;
      bit_cnt  <= '0;
      lead_cnt <= '0;
      stop_cnt <= 1'b0;
      par_bit  <= 1'b0;
      line     <= 1'b1;
    end else begin
      state    <= state_n;
      lead_cnt <= (state == S_LEAD) ? (tick ? lead_cnt + 1'b1 : lead_cnt) : '0;
      stop_cnt <= (state == S_STOP) ? (tick ? ~stop_cnt : stop_cnt) : 1'b0;
      if (take) begin
        shift   <= hold_data;
        par_bit <= parity_of(hold_data, par_odd);
        bit_cnt <= '0;
        line    <= 1'b0;
      end else if (tick) begin
        unique case (state)
          S_START: line <= shift[0];
          S_DATA: begin
            shift   <= shift >> 1;
            bit_cnt <= bit_cnt + 1'b1;
            line    <= (bit_cnt == BIT_LAST) ? (par_en ? par_bit : 1'b1) : shift[1];
          end
          default: line <= 1'b1;
        endcase
      end
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_START) |-> !line);
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP || state == S_TAIL || state == S_IDLE) |-> line);
  assert_lead_before_start_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && $past(state) == S_LEAD) |-> $past(tick));
endmodule

// File: rtl/rs485_uart_tx.sv
`timescale 1ns/1ps
module rs485_uart_tx
  import rs485_tx_pkg::*;
#(
  parameter int unsigned LEAD_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 baud_tick,
  input  logic                 wr_en,
  input  logic [TX_DATA_W-1:0] wr_data,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 two_stop,
  input  logic                 de_active_low,
  input  logic                 irq_en,
  output logic                 txd,
  output logic                 drv_en,
  output logic                 empty,
  output logic                 overrun,
  output logic                 irq
);
  logic [TX_DATA_W-1:0] hold_data;
  logic pending, take, first_done, empty_nx, de_nx, de_on;

  txu_hold_reg u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .first_done(first_done), .hold_data(hold_data),
    .pending(pending), .empty(empty), .empty_nx(empty_nx), .overrun(overrun)
  );

  txu_frame_seq #(.LEAD_TICKS(LEAD_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick(baud_tick), .pending(pending),
    .hold_data(hold_data), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .take(take), .first_done(first_done),
    .de_nx(de_nx), .line(txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de_on  <= 1'b0;
      drv_en <= de_active_low;
      irq    <= 1'b0;
    end else begin
      de_on  <= de_nx;
      drv_en <= de_nx ^ de_active_low;
      irq    <= empty_nx & irq_en;
    end
  end

  assert_irq_needs_empty_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> empty);
  assert_mark_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    !de_on |-> txd);
  assert_de_closes_on_mark_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(de_on) |-> $past(txd));
endmodule

// File: tb/rs485_uart_tx_tb.sv
`timescale 1ns/1ps
module rs485_uart_tx_tb;
  localparam int DIV = 8;
  localparam int WATCH = 200000;

  logic clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic par_en = 0, par_odd = 0, two_stop = 0, de_active_low = 0, irq_en = 0;
  logic txd, drv_en, empty, overrun, irq;

  int checks = 0, errors = 0;
  int cyc = 0, divcnt = 0, t_de = 0, chain_start = 0;
  logic de_prev = 1'b0;

  rs485_uart_tx u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .de_active_low(de_active_low), .irq_en(irq_en), .txd(txd), .drv_en(drv_en),
    .empty(empty), .overrun(overrun), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    divcnt    <= (divcnt == DIV - 1) ? 0 : divcnt + 1;
    baud_tick <= (divcnt == DIV - 1);
    if ((drv_en ^ de_active_low) && !de_prev) t_de <= cyc;
    de_prev <= drv_en ^ de_active_low;
  end

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    logic p = 1'b0;
    for (int i = 0; i < 8; i++) p = p ^ d[i];
    return p ^ odd;
  endfunction

  function automatic int exp_len(input logic pe, input logic ts);
    return ts ? (pe ? 12 : 11) : (pe ? 11 : 10);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Follows one frame. chained: the start bit began at chain_start with no lead.
  // nxt_valid: write nxt as soon as empty rises, so the next frame follows at once.
  task automatic watch_frame(input logic [7:0] exp, input logic chained,
                             input logic nxt_valid, input logic [7:0] nxt);
    int s, n, endc;
    logic [7:0] got = '0;
    logic de_gap = 1'b0;
    n = exp_len(par_en, two_stop);
    if (chained) s = chain_start;
    else begin
      while (txd !== 1'b0) @(negedge clk);
      s = cyc;
      check((s - t_de >= DIV) && (s - t_de <= 2 * DIV), "R5 lead", s - t_de, DIV);
    end
    endc = s + n * DIV;
    while (cyc <= endc + 1) begin
      if (cyc <= endc && !(drv_en ^ de_active_low)) de_gap = 1'b1;
      if (cyc == s + DIV - 1) begin
        check(empty == 1'b0, "R9 empty before start end", empty, 0);
        check(irq == (empty & irq_en), "R11 irq", irq, empty & irq_en);
      end
      if (cyc == s + DIV) begin
        check(empty == 1'b1, "R9 empty at start end", empty, 1);
        check(irq == (empty & irq_en), "R11 irq", irq, empty & irq_en);
        if (nxt_valid) wr_en = 1'b1;
        wr_data = nxt;
      end
      if (cyc == s + DIV + 1) wr_en = 1'b0;
      if (cyc == s + DIV / 2) check(txd == 1'b0, "R2 start bit", txd, 0);
      for (int i = 0; i < 8; i++)
        if (cyc == s + DIV * (1 + i) + DIV / 2) got[i] = txd;
      if (par_en && cyc == s + 9 * DIV + DIV / 2)
        check(txd == exp_par(exp, par_odd), "R3 parity", txd, exp_par(exp, par_odd));
      if (cyc == s + (9 + par_en) * DIV + DIV / 2) check(txd == 1'b1, "R4 stop1", txd, 1);
      if (cyc == endc - 1) check(txd == 1'b1, "R4 stop end", txd, 1);
      if (cyc == endc) begin
        if (nxt_valid) check(txd == 1'b0, "R7 next start", txd, 0);
        else check(txd == 1'b1, "R4 mark after stop", txd, 1);
        check(drv_en == !de_active_low, "R6 de held at stop end", drv_en, !de_active_low);
      end
      if (cyc == endc + 1) begin
        if (nxt_valid) check(drv_en == !de_active_low, "R7 de continuous", drv_en, !de_active_low);
        else check(drv_en == de_active_low, "R6 de off", drv_en, de_active_low);
      end
      @(negedge clk);
    end
    check(got == exp, "R2 data", got, exp);
    check(!de_gap, "R7/R8 de level during frame", de_gap, 0);
    chain_start = endc;
  endtask

  initial begin
    #(WATCH * 5.0);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCH);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic ch;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1 && empty == 1 && overrun == 0 && irq == 0 && drv_en == 0, "R1 reset",
          {txd, drv_en, empty, overrun, irq}, 5'b10100);
    irq_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check(irq == 1'b1, "R11 idle irq", irq, 1);

    // directed: plain frame, even parity, odd parity with two stops
    do_write(8'hA5); watch_frame(8'hA5, 0, 0, 0);
    par_en = 1; do_write(8'h37); watch_frame(8'h37, 0, 0, 0);
    par_odd = 1; two_stop = 1; do_write(8'h80); watch_frame(8'h80, 0, 0, 0);
    par_en = 0; par_odd = 0; two_stop = 0;

    // back-to-back pair
    do_write(8'h01); watch_frame(8'h01, 0, 1, 8'hFE); watch_frame(8'hFE, 1, 0, 0);

    // overrun: second write ignored
    check(overrun == 1'b0, "R10 no overrun yet", overrun, 0);
    do_write(8'h5A); do_write(8'hC3);
    check(overrun == 1'b1, "R10 overrun set", overrun, 1);
    watch_frame(8'h5A, 0, 0, 0);
    repeat (3 * DIV) @(negedge clk);
    check(txd == 1'b1 && drv_en == 1'b0, "R10 ignored byte not sent", txd, 1);
    check(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

    // inverted enable, interrupt off
    de_active_low = 1; irq_en = 0;
    @(negedge clk); @(negedge clk);
    check(drv_en == 1'b1, "R8 idle high", drv_en, 1);
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    do_write(8'h3C); watch_frame(8'h3C, 0, 0, 0);
    de_active_low = 0; irq_en = 1;
    @(negedge clk); @(negedge clk);

    // random frames, some chained
    ch = 0; d = 8'($urandom);
    for (int k = 0; k < 24; k++) begin
      if (!ch) begin
        par_en = 1'($urandom); par_odd = 1'($urandom); two_stop = 1'($urandom);
        repeat (1 + ($urandom % 5)) @(negedge clk);
        do_write(d);
      end
      d2 = 8'($urandom);
      if ((k != 23) && ($urandom % 3 == 0)) begin
        watch_frame(d, ch, 1, d2); ch = 1;
      end else begin
        watch_frame(d, ch, 0, 0); ch = 0;
      end
      d = d2;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule